// File: doc/BRIEF.md
# Paired-Priority Vectored Interrupt Controller

This block collects nine peripheral interrupt lines into one vectored request to a processor core. Each input passes through a synchroniser and an edge detector whose polarity is chosen per channel. A detected edge sets a pending bit. A mask bit per channel decides whether that pending bit may request service. A second edge that arrives before the first has been served sets a sticky overrun flag.

The ten channel slots are grouped as five pairs, numbered 0 to 9. The last slot has no input and can never request. Software sets a 2-bit priority field for each pair. The even member of a pair gets that field with a 0 appended as its lowest bit, and the odd member gets a 1, which yields a 3-bit level. The lowest level wins. If levels are equal, the lower slot number wins. The winner's slot number appears in bits 4:1 of the vector output. The other vector bits come from a base field that software writes. A one-cycle acknowledge from the core clears the pending bit of the channel that is winning at that moment.

Software reaches all state through a small byte-wide register port. Writes are synchronous and reads are combinational. The register map is:

| Address | Contents |
|---|---|
| 0 | pending bits of slots 7:0 (read-only) |
| 1 | pending bits of slots 9:8 in bits 1:0 (read-only) |
| 2 | mask bits of slots 7:0 |
| 3 | mask bits of slots 9:8 in bits 1:0 |
| 4 | edge-select bits of slots 7:0 |
| 5 | edge-select bit of slot 8 in bit 0 |
| 6 | priority fields of pairs 0 to 3, two bits each, pair p at bits 2p+1:2p |
| 7 | priority field of pair 4 in bits 1:0 |
| 8 | vector: base bits 7:5 and 0 are writable, bits 4:1 are read-only |
| 9 | overrun flags of slots 7:0 (write 1 to clear) |
| 10 | overrun flags of slots 9:8 in bits 1:0 (write 1 to clear) |

Top module: `pair_irq_ctrl`

## Requirements
- R1: After reset, all pending bits, overrun flags and mask bits read 0, and `irq_req` is 0. Every edge-select bit reads 1 and every priority field reads 0.
- R2: With edge-select 1, a rising input sets the channel's pending bit three clock edges after the input changes. A falling input sets nothing.
- R3: With edge-select 0, a falling input sets the pending bit. A rising input sets nothing.
- R4: A pending channel whose mask bit is 0 keeps its pending bit. It does not assert `irq_req` and does not take part in selection.
- R5: A channel's level is its pair's 2-bit field followed by the slot's lowest bit. The unmasked pending channel with the numerically lowest level wins, and its slot number (0 to 8) drives vector bits 4:1.
- R6: When two unmasked pending channels have the same level, the one with the lower slot number wins.
- R7: A pulse on `irq_ack` while `irq_req` is 1 clears the pending bit of the current winner only. `irq_req` falls once no unmasked channel is pending.
- R8: An edge event on a channel that is already pending, in a cycle without an acknowledge to that channel, sets its overrun flag. The flag stays set until software writes 1 to it. If a set and a clear happen in the same cycle, the set wins.
- R9: Slot 9 has no input. Its pending bit (bit 1 at address 1) always reads 0.
- R10: Vector bits 7:5 and 0 equal the values last written to the same bit positions at address 8.
- R11: An `irq_ack` while `irq_req` is 0 changes no pending bit.
- R12: When an edge event and an acknowledge hit the same channel in the same cycle, its pending bit stays 1 and its overrun flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 9 | Asynchronous interrupt inputs, slots 0 to 8 |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_ack | input | 1 | One-cycle acknowledge from the core |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | 8 | Vector: base bits plus winning slot number |

## Verification
The assertions check several properties on every cycle:
- A request always names a channel that is both pending and unmasked.
- An edge always leaves a pending bit set.
- An acknowledge clears only when no new edge arrives in the same cycle.
- Overrun flags are sticky.
- An acknowledge with no request never clears anything.
- A fully masked controller never requests.

Several behaviours can only be shown by the bench's scenarios. These are the actual winner order across mixed levels, the tie-break between equal levels, the vector encoding with a programmed base, polarity selection, and the exact cycle in which an edge and an acknowledge coincide.

// File: rtl/pirq_pkg.sv
`timescale 1ns/1ps
package pirq_pkg;
    localparam int NUM_PAIRS = 5;
    localparam int NUM_SLOTS = 2 * NUM_PAIRS;
    localparam int NUM_LIVE  = NUM_SLOTS - 1;
    localparam int IDX_W     = $clog2(NUM_SLOTS);
    localparam int FIELD_W   = 2;
    localparam int LEVEL_W   = FIELD_W + 1;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int LO_W      = DATA_W;

    typedef enum logic [ADDR_W-1:0] {
        A_PEND_LO = 4'd0,
        A_PEND_HI = 4'd1,
        A_MASK_LO = 4'd2,
        A_MASK_HI = 4'd3,
        A_EDGE_LO = 4'd4,
        A_EDGE_HI = 4'd5,
        A_PRIO_LO = 4'd6,
        A_PRIO_HI = 4'd7,
        A_VECT    = 4'd8,
        A_OVR_LO  = 4'd9,
        A_OVR_HI  = 4'd10
    } reg_addr_e;

    typedef struct packed {
        logic               valid;
        logic [IDX_W-1:0]   idx;
        logic [LEVEL_W-1:0] level;
    } win_t;

    // Level of a slot: the pair's field, then the slot's parity as the lowest bit.
    function automatic logic [LEVEL_W-1:0] slot_level(input logic [FIELD_W-1:0] field,
                                                       input int slot);
        logic odd;
        odd = (slot % 2) != 0;
        return {field, odd};
    endfunction
endpackage

// File: rtl/pirq_chan.sv
`timescale 1ns/1ps
module pirq_chan #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic irq_raw,
    input  logic rise_sel,
    input  logic ack_hit,
    input  logic ovr_clr,
    output logic pending,
    output logic overrun
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;
    logic                   evt;

    assign cur = sync_q[SYNC_STAGES-1];
    assign evt = rise_sel ? (cur & ~prev_q) : (~cur & prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], irq_raw};
            prev_q <= cur;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          pending <= 1'b0;
        else if (evt)     pending <= 1'b1;
        else if (ack_hit) pending <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                            overrun <= 1'b0;
        else if (evt && pending && !ack_hit) overrun <= 1'b1;
        else if (ovr_clr)                   overrun <= 1'b0;
    end

    // R2: a detected edge leaves the channel pending
    p_edge_sets_r2: assert property (@(posedge clk) disable iff (rst) evt |=> pending);
    // R7: an acknowledge without a coinciding edge clears the bit
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (pending && ack_hit && !evt) |=> !pending);
    // R8: overrun is sticky until cleared
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ovr_clr) |=> overrun);
    // R12: edge and acknowledge together keep the bit and raise no overrun
    p_ack_edge_r12: assert property (@(posedge clk) disable iff (rst)
        (evt && ack_hit && !overrun) |=> (pending && !overrun));
endmodule

// File: rtl/pirq_arbiter.sv
`timescale 1ns/1ps
module pirq_arbiter
    import pirq_pkg::*;
#(
    parameter int N = NUM_SLOTS
) (
    input  logic [N-1:0]              req,
    input  logic [N-1:0][LEVEL_W-1:0] level,
    output win_t                      win
);
    // Ascending scan, replacing only on a strictly lower level: ties keep the lower slot.
    always_comb begin
        win = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!win.valid || level[i] < win.level)) begin
                win.valid = 1'b1;
                win.idx   = IDX_W'(i);
                win.level = level[i];
            end
        end
    end
endmodule

// File: rtl/pair_irq_ctrl.sv
`timescale 1ns/1ps
module pair_irq_ctrl
    import pirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_LIVE-1:0] irq_in,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                irq_ack,
    output logic                irq_req,
    output logic [DATA_W-1:0]   irq_vector
);
    localparam int HI_W   = NUM_SLOTS - LO_W;
    localparam int LO_PRS = LO_W / FIELD_W;

    logic [NUM_SLOTS-1:0]              pending, overrun, mask_q, live_req;
    logic [NUM_LIVE-1:0]               rise_q, ack_hit, ovr_clr;
    logic [NUM_PAIRS-1:0][FIELD_W-1:0] pfield_q;
    logic [3:0]                        base_q;
    logic [NUM_SLOTS-1:0][LEVEL_W-1:0] level;
    win_t                              win;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            rise_q   <= '1;
            pfield_q <= '0;
            base_q   <= '0;
        end else if (reg_wr) begin
            case (reg_addr_e'(reg_addr))
                A_MASK_LO: mask_q[LO_W-1:0]          <= reg_wdata;
                A_MASK_HI: mask_q[NUM_SLOTS-1:LO_W]  <= reg_wdata[HI_W-1:0];
                A_EDGE_LO: rise_q[LO_W-1:0]          <= reg_wdata;
                A_EDGE_HI: rise_q[NUM_LIVE-1:LO_W]   <= reg_wdata[NUM_LIVE-LO_W-1:0];
                A_PRIO_LO: for (int p = 0; p < LO_PRS; p++)
                               pfield_q[p] <= reg_wdata[FIELD_W*p +: FIELD_W];
                A_PRIO_HI: pfield_q[NUM_PAIRS-1]     <= reg_wdata[FIELD_W-1:0];
                A_VECT:    base_q <= {reg_wdata[DATA_W-1:IDX_W+1], reg_wdata[0]};
                default: ;
            endcase
        end
    end

    always_comb begin
        ovr_clr = '0;
        if (reg_wr && reg_addr_e'(reg_addr) == A_OVR_LO) ovr_clr[LO_W-1:0] = reg_wdata;
        if (reg_wr && reg_addr_e'(reg_addr) == A_OVR_HI)
            ovr_clr[NUM_LIVE-1:LO_W] = reg_wdata[NUM_LIVE-LO_W-1:0];
    end

    always_comb begin
        for (int i = 0; i < NUM_LIVE; i++)
            ack_hit[i] = irq_ack && win.valid && (win.idx == IDX_W'(i));
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign level[s] = slot_level(pfield_q[s/2], s);
        if (s < NUM_LIVE) begin : g_live
            pirq_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
                .clk(clk), .rst(rst), .irq_raw(irq_in[s]), .rise_sel(rise_q[s]),
                .ack_hit(ack_hit[s]), .ovr_clr(ovr_clr[s]),
                .pending(pending[s]), .overrun(overrun[s])
            );
        end else begin : g_rsvd
            assign pending[s] = 1'b0;
            assign overrun[s] = 1'b0;
        end
    end

    assign live_req = pending & mask_q;

    pirq_arbiter #(.N(NUM_SLOTS)) u_arb (.req(live_req), .level(level), .win(win));

    assign irq_req    = win.valid;
    assign irq_vector = {base_q[3:1], win.idx, base_q[0]};

    always_comb begin
        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            A_PEND_LO: reg_rdata = pending[LO_W-1:0];
            A_PEND_HI: reg_rdata[HI_W-1:0] = pending[NUM_SLOTS-1:LO_W];
            A_MASK_LO: reg_rdata = mask_q[LO_W-1:0];
            A_MASK_HI: reg_rdata[HI_W-1:0] = mask_q[NUM_SLOTS-1:LO_W];
            A_EDGE_LO: reg_rdata = rise_q[LO_W-1:0];
            A_EDGE_HI: reg_rdata[NUM_LIVE-LO_W-1:0] = rise_q[NUM_LIVE-1:LO_W];
            A_PRIO_LO: for (int p = 0; p < LO_PRS; p++)
                           reg_rdata[FIELD_W*p +: FIELD_W] = pfield_q[p];
            A_PRIO_HI: reg_rdata[FIELD_W-1:0] = pfield_q[NUM_PAIRS-1];
            A_VECT:    reg_rdata = irq_vector;
            A_OVR_LO:  reg_rdata = overrun[LO_W-1:0];
            A_OVR_HI:  reg_rdata[HI_W-1:0] = overrun[NUM_SLOTS-1:LO_W];
            default: ;
        endcase
    end

    // R5: the request always names a pending, unmasked channel
    p_win_live_r5: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (pending[win.idx] && mask_q[win.idx]));
    // R4: nothing requests while every channel is masked
    p_all_masked_r4: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq_req);
    // R11: an acknowledge with no request clears no pending bit
    p_idle_ack_r11: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !irq_req) |=> (($past(pending) & ~pending) == '0));
endmodule

// File: tb/pair_irq_ctrl_bench.sv
`timescale 1ns/1ps
module pair_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] irq_in = '0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_ack = 1'b0;
    logic       irq_req;
    logic [7:0] irq_vector;

    int n_vec = 0;
    int n_miss = 0;
    bit done = 0;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    pair_irq_ctrl u_pair_irq_ctrl (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_vector(irq_vector)
    );

    // Monitor: pop each expected item and compare with what the design shows now.
    initial begin
        forever begin
            item_t it;
            logic [7:0] act;
            wait (sb_q.size() != 0);
            #0.2;
            it = sb_q.pop_front();
            if (it.sel == 16)      act = {7'b0, irq_req};
            else if (it.sel == 17) act = irq_vector;
            else                   act = reg_rdata;
            n_vec++;
            if (act !== it.exp) begin
                n_miss++;
                $display("FAIL %s sel=%0d: got %h expected %h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    // Driver: select what to observe and push the expected value.
    task automatic chk(input int sel, input logic [7:0] exp, input string tag);
        item_t it;
        if (sel < 16) reg_addr = sel[3:0];
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic drive(input logic [8:0] v);
        @(negedge clk);
        irq_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(0, 8'h00, "R1 pending lo");
        chk(1, 8'h00, "R1 pending hi");
        chk(2, 8'h00, "R1 mask");
        chk(9, 8'h00, "R1 overrun");
        chk(4, 8'hFF, "R1 edge select");
        chk(6, 8'h00, "R1 priority");
        chk(16, 8'h00, "R1 request");

        wr(2, 8'hFF); wr(3, 8'h03);
        drive(9'h008);
        chk(0, 8'h08, "R2 rising sets F1");
        chk(16, 8'h01, "R2 request");
        chk(17, 8'h06, "R5 vector idx 3");
        drive(9'h000);
        chk(0, 8'h08, "R2 falling ignored");
        chk(9, 8'h00, "R2 no overrun");
        ack();
        chk(0, 8'h00, "R7 ack clears");
        chk(16, 8'h00, "R7 request drops");

        wr(2, 8'hFE);
        drive(9'h001);
        chk(0, 8'h01, "R4 masked stays pending");
        chk(16, 8'h00, "R4 masked no request");
        ack();
        chk(0, 8'h01, "R11 idle ack ignored");
        wr(2, 8'hFF);
        chk(16, 8'h01, "R4 unmask requests");
        wr(8, 8'hA1);
        chk(8, 8'hA1, "R10 base bits");
        chk(17, 8'hA1, "R10 vector port");
        ack();
        drive(9'h000);
        chk(0, 8'h00, "R7 E0 cleared");

        wr(6, 8'h1B); wr(7, 8'h00);
        chk(6, 8'h1B, "R5 priority readback");
        drive(9'h029);
        chk(0, 8'h29, "R2 three pending");
        chk(17, 8'hAB, "R5 G1 wins level 3");
        ack();
        chk(0, 8'h09, "R7 only winner cleared");
        chk(17, 8'hA7, "R5 F1 next level 5");
        ack();
        chk(17, 8'hA1, "R5 E0 last level 6");
        ack();
        chk(16, 8'h00, "R7 all served");

        drive(9'h169);
        chk(0, 8'h40, "R2 H0 pending");
        chk(1, 8'h01, "R9 slot 9 never pending");
        chk(17, 8'hAD, "R6 tie H0 before I0");
        ack();
        chk(17, 8'hB1, "R6 I0 after H0");
        ack();
        chk(16, 8'h00, "R7 tie pair served");

        drive(9'h000);
        drive(9'h002);
        chk(0, 8'h02, "R2 E1 pending");
        drive(9'h000);
        drive(9'h002);
        chk(9, 8'h02, "R8 overrun set");
        chk(0, 8'h02, "R8 still pending");
        wr(9, 8'h02);
        chk(9, 8'h00, "R8 write-one clear");
        ack();
        drive(9'h000);

        wr(4, 8'hFB);
        drive(9'h004);
        chk(0, 8'h00, "R3 rising ignored");
        drive(9'h000);
        chk(0, 8'h04, "R3 falling sets F0");
        ack();
        wr(4, 8'hFF);

        drive(9'h001);
        chk(0, 8'h01, "R12 E0 pending");
        drive(9'h000);
        irq_in = 9'h001;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk(0, 8'h01, "R12 set wins over ack");
        chk(9, 8'h00, "R12 no overrun");
        ack();
        chk(0, 8'h00, "R12 later ack clears");
        chk(1, 8'h00, "R9 slot 9 still clear");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end
endmodule